// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general-purpose register storage of a multi-mode processor core. It has sixteen architectural registers, addressed by a 4-bit number, with two combinational read ports and one clocked write port. The physical copy that a register number selects depends on the current operating mode. The low registers and the program counter exist once and every mode shares them. The fast-interrupt mode has its own copies of registers 8 to 12. Each of the five exception modes has its own stack pointer (register 13) and link register (register 14).

The block also holds the current status word and one saved status word for each exception mode. It exports the two interrupt-mask bits of the current status. Writes to register 15 are aligned according to the instruction-state bits of the current status. A force-user input makes register accesses use the user-mode copies of registers 8 to 14. Privileged code uses it to save or restore user context. Instruction decode, the ALU and exception-entry sequencing stay outside this block and drive its ports.

Top module: `banked_regfile`

## Requirements
- R1: After a cycle with `rst_n` low, every register reads zero in every mode, `sr_q` equals 32'h0000_00D3 (supervisor mode, both interrupt masks set), and `spsr_rdata` reads zero.
- R2: Registers 0 to 7 and register 15 have a single copy. A value written in any mode is read back in every mode.
- R3: In fast-interrupt mode, registers 8 to 12 select a private copy. Every other mode shares one common copy of them.
- R4: Registers 13 and 14 have one private pair for each of the fast-interrupt, interrupt, supervisor, abort and undefined modes. User mode, system mode and any unlisted mode code all share the user pair.
- R5: The mode is `sr_q[4:0]`, encoded as user 10000, fast-interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. The user and system register views are identical.
- R6: Each exception mode has its own saved status word. The current mode selects it for `spsr_we` and `spsr_rdata`. In user, system or unlisted modes, `spsr_rdata` is zero and writes leave all saved words unchanged.
- R7: The status word holds N, Z, C and V in bits 31:28, a sticky flag in bit 27, the byte-code state bit J in bit 24, the interrupt mask in bit 7, the fast-interrupt mask in bit 6, the thumb bit T in bit 5 and the mode in bits 4:0. `irq_mask` equals bit 7 and `fiq_mask` equals bit 6.
- R8: A write to register 15 is aligned by the status word in force before the edge. With T=1, bit 0 is stored as zero. With T=0 and J=0, bits 1:0 are stored as zero. With T=0 and J=1, the value is stored unchanged.
- R9: Writes take effect at the rising clock edge. A read of the register being written in the same cycle returns the old value on both ports. The mode used for a register or saved-word write is the mode before any status write in the same cycle.
- R10: With `user_bank` high, registers 8 to 14 map to the user copies for reads and writes in any mode. It has no effect on registers 0 to 7, register 15 or the saved status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 4 | Architectural register number for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Architectural register number for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Architectural register number to write |
| wr_data | input | DATA_W | Register write data |
| user_bank | input | 1 | Force user copies of registers 8 to 14 |
| sr_we | input | 1 | Current status write enable |
| sr_wdata | input | 32 | New current status value |
| sr_q | output | 32 | Current status word |
| spsr_we | input | 1 | Saved status write enable for the current mode |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_rdata | output | 32 | Saved status word of the current mode |
| irq_mask | output | 1 | Normal interrupt request masked |
| fiq_mask | output | 1 | Fast interrupt request masked |

## Verification
The bench builds the block with its default DATA_W of 32. This is the width the status layout requires, and it gives 31 physical register slots. At that size a full sweep is practical. Every register is written in every one of the seven defined modes and one unlisted mode code, and all sixteen registers are then read back on both ports in each of those eight modes. The bench computes the expected values from its own slot arithmetic. That sweep covers every sharing and privacy relation. Directed sequences then cover the three alignment cases, the read-during-write ordering, the force-user path and the mask outputs.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
// Shared types and layout constants for the banked register file.
// Assumes a 16-entry architectural register space and a 32-bit status word.
package bank_pkg;
    localparam int SR_W     = 32;
    localparam int HI_BASE  = 8;    // first register that FIQ mode banks
    localparam int SP_IDX   = 13;   // first register of the per-mode pair
    localparam int PC_IDX   = 15;
    localparam int NHI      = SP_IDX - HI_BASE;
    localparam int NPRIV    = 5;    // exception modes with private state
    localparam int P_USR_HI = HI_BASE;
    localparam int P_FIQ_HI = P_USR_HI + NHI;
    localparam int P_PAIR   = P_FIQ_HI + NHI;
    localparam int P_PC     = P_PAIR + 2 * (NPRIV + 1);
    localparam int NPHYS    = P_PC + 1;
    localparam int PW       = $clog2(NPHYS);

    // status word bit positions
    localparam int SR_J = 24;
    localparam int SR_I = 7;
    localparam int SR_F = 6;
    localparam int SR_T = 5;
    localparam logic [SR_W-1:0] SR_RESET = 32'h0000_00D3;

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    // Reduce a mode field to its storage bank; unknown codes act as user.
    function automatic bank_e bank_of(logic [4:0] m);
        case (m)
            MODE_FIQ: return BK_FIQ;
            MODE_IRQ: return BK_IRQ;
            MODE_SVC: return BK_SVC;
            MODE_ABT: return BK_ABT;
            MODE_UND: return BK_UND;
            default:  return BK_USR;
        endcase
    endfunction
endpackage

// File: rtl/rf_bank_map.sv
`timescale 1ns/1ps
// Maps an architectural register number to a physical storage slot.
// Assumes slot layout from bank_pkg: shared low registers, two copies of
// the high group, one r13/r14 pair per bank, then the program counter.
module rf_bank_map
    import bank_pkg::*;
(
    input  logic [3:0]    arch,
    input  bank_e         bank,
    input  logic          usr_force,
    output logic [PW-1:0] phys
);
    bank_e eff;

    // Purpose: pick the slot for this register under the effective bank.
    always_comb begin
        eff = usr_force ? BK_USR : bank;
        if (arch == 4'(PC_IDX))
            phys = PW'(P_PC);
        else if (arch < 4'(HI_BASE))
            phys = PW'(arch);
        else if (arch < 4'(SP_IDX))
            phys = PW'((eff == BK_FIQ) ? P_FIQ_HI : P_USR_HI) + PW'(arch - 4'(HI_BASE));
        else
            phys = PW'(P_PAIR) + PW'({eff, 1'b0}) + PW'(arch - 4'(SP_IDX));
    end
endmodule

// File: rtl/rf_status.sv
`timescale 1ns/1ps
// Current status word plus one saved status word per exception mode.
// Assumes the saved-word access uses the mode held before the edge.
module rf_status
    import bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sr_we,
    input  logic [SR_W-1:0] sr_wdata,
    input  logic            spsr_we,
    input  logic [SR_W-1:0] spsr_wdata,
    output logic [SR_W-1:0] sr_q,
    output logic [SR_W-1:0] spsr_rdata,
    output bank_e           bank,
    output logic            thumb,
    output logic            jstate
);
    logic [NPRIV-1:0][SR_W-1:0] spsr_q;
    logic [2:0]                 sidx;

    // Purpose: decode the current mode and the saved-word slot.
    always_comb begin
        bank   = bank_of(sr_q[4:0]);
        sidx   = 3'(bank) - 3'd1;
        thumb  = sr_q[SR_T];
        jstate = sr_q[SR_J];
        spsr_rdata = (bank == BK_USR) ? '0 : spsr_q[sidx];
    end

    // Purpose: hold the current status word.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= SR_RESET;
        else if (sr_we) sr_q <= sr_wdata;
    end

    // Purpose: hold the saved status words, one per exception bank.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spsr_q <= '0;
        else if (spsr_we && bank != BK_USR)
            spsr_q[sidx] <= spsr_wdata;
    end

    // R1: reset loads supervisor mode with both masks set
    a_r1_reset_status: assert property (@(posedge clk)
        !rst_n |=> sr_q == SR_RESET);
    // R6: a saved-word write outside an exception mode changes nothing
    a_r6_spsr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == BK_USR && spsr_we) |=> $stable(spsr_q));
    // R6: a write in an exception mode is read back in that mode
    a_r6_spsr_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bank != BK_USR && spsr_we && !sr_we) |=> spsr_rdata == $past(spsr_wdata));
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
// Mode-banked register file: two read ports, one write port, status words.
// Assumes DATA_W >= 32 so the status layout and PC alignment fit.
module banked_regfile
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              user_bank,
    input  logic              sr_we,
    input  logic [31:0]       sr_wdata,
    output logic [31:0]       sr_q,
    input  logic              spsr_we,
    input  logic [31:0]       spsr_wdata,
    output logic [31:0]       spsr_rdata,
    output logic              irq_mask,
    output logic              fiq_mask
);
    localparam int NPORT = 3;   // read A, read B, write
    localparam logic [PW-1:0] PH_FIQ_LO = PW'(P_FIQ_HI);
    localparam logic [PW-1:0] PH_FIQ_HI = PW'(P_FIQ_HI + NHI);
    localparam logic [PW-1:0] PH_FIQ_SP = PW'(P_PAIR + 2);
    localparam logic [PW-1:0] PH_USR_SP = PW'(P_PAIR);
    localparam logic [PW-1:0] PH_PC     = PW'(P_PC);

    bank_e             bank;
    logic              thumb, jstate;
    logic [3:0]        port_arch [NPORT];
    logic [PW-1:0]     port_phys [NPORT];
    logic [DATA_W-1:0] rf_q [NPHYS];
    logic [DATA_W-1:0] pc_wdata;

    rf_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_we      (sr_we),
        .sr_wdata   (sr_wdata),
        .spsr_we    (spsr_we),
        .spsr_wdata (spsr_wdata),
        .sr_q       (sr_q),
        .spsr_rdata (spsr_rdata),
        .bank       (bank),
        .thumb      (thumb),
        .jstate     (jstate)
    );

    assign port_arch[0] = rd_a_idx;
    assign port_arch[1] = rd_b_idx;
    assign port_arch[2] = wr_idx;

    for (genvar g = 0; g < NPORT; g++) begin : g_map
        rf_bank_map u_map (
            .arch      (port_arch[g]),
            .bank      (bank),
            .usr_force (user_bank),
            .phys      (port_phys[g])
        );
    end

    // Purpose: export the interrupt masks and read the two ports.
    always_comb begin
        irq_mask  = sr_q[SR_I];
        fiq_mask  = sr_q[SR_F];
        rd_a_data = rf_q[port_phys[0]];
        rd_b_data = rf_q[port_phys[1]];
    end

    // Purpose: align a program-counter write to the instruction state.
    always_comb begin
        if (thumb)       pc_wdata = {wr_data[DATA_W-1:1], 1'b0};
        else if (jstate) pc_wdata = wr_data;
        else             pc_wdata = {wr_data[DATA_W-1:2], 2'b00};
    end

    // Purpose: commit the write port into the selected slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) rf_q[i] <= '0;
        end else if (wr_en) begin
            rf_q[port_phys[2]] <= (wr_idx == 4'(PC_IDX)) ? pc_wdata : wr_data;
        end
    end

    // R8: word state leaves the two low PC bits clear
    a_r8_pc_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 4'd15 && !thumb && !jstate) |=> rf_q[PH_PC][1:0] == 2'b00);
    // R8: halfword state leaves PC bit 0 clear
    a_r8_pc_half: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 4'd15 && thumb) |=> rf_q[PH_PC][0] == 1'b0);
    // R3: FIQ writes to r8..r14 land in its private slots only
    a_r3_fiq_private: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank == BK_FIQ && !user_bank && wr_idx >= 4'd8 && wr_idx <= 4'd14)
        |-> ((port_phys[2] >= PH_FIQ_LO && port_phys[2] < PH_FIQ_HI)
             || port_phys[2] == PH_FIQ_SP || port_phys[2] == PH_FIQ_SP + 1'b1));
    // R10: forced user access never reaches a banked copy
    a_r10_user_force: assert property (@(posedge clk) disable iff (!rst_n)
        (user_bank && wr_en && wr_idx >= 4'd8 && wr_idx <= 4'd14)
        |-> (port_phys[2] < PH_FIQ_LO
             || port_phys[2] == PH_USR_SP || port_phys[2] == PH_USR_SP + 1'b1));
endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, user_bank, sr_we, spsr_we;
    logic [31:0] sr_wdata, sr_q, spsr_wdata, spsr_rdata;
    logic        irq_mask, fiq_mask;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] mdl [0:399];
    logic [31:0] msp [0:5];
    logic [31:0] cur_sr;

    always #10 clk = ~clk;   // 50 MHz

    banked_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .user_bank(user_bank),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_q(sr_q),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata),
        .irq_mask(irq_mask), .fiq_mask(fiq_mask)
    );

    // bank number from the mode codes of R5; 0 means user view
    function automatic int kof(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    // model key for a register seen in a mode (R2, R3, R4, R10)
    function automatic int slot(logic [4:0] m, int r, bit ub);
        if (r < 8 || r == 15) return r;
        if (r < 13) return (kof(m) == 1 && !ub) ? 100 + r : r;
        return 200 + 16 * (ub ? 0 : kof(m)) + r;
    endfunction

    function automatic string tag_of(int r);
        if (r < 8 || r == 15) return "R2";
        if (r < 13) return "R3";
        return "R4";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_sr(logic [31:0] v);
        @(negedge clk);
        sr_we = 1'b1; sr_wdata = v;
        @(negedge clk);
        sr_we = 1'b0;
        cur_sr = v;
    endtask

    task automatic wr(int r, logic [31:0] v);
        logic [31:0] m;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = r[3:0]; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        m = v;
        if (r == 15) begin   // R8 alignment
            if (cur_sr[5])       m = v & ~32'd1;
            else if (!cur_sr[24]) m = v & ~32'd3;
        end
        mdl[slot(cur_sr[4:0], r, user_bank)] = m;
    endtask

    task automatic wr_spsr(logic [31:0] v);
        @(negedge clk);
        spsr_we = 1'b1; spsr_wdata = v;
        @(negedge clk);
        spsr_we = 1'b0;
        if (kof(cur_sr[4:0]) != 0) msp[kof(cur_sr[4:0])] = v;
    endtask

    task automatic rd(int ra, int rb, string req);
        rd_a_idx = ra[3:0]; rd_b_idx = rb[3:0];
        #2;
        check(req, rd_a_data, mdl[slot(cur_sr[4:0], ra, user_bank)]);
        check(req, rd_b_data, mdl[slot(cur_sr[4:0], rb, user_bank)]);
    endtask

    task automatic chk_spsr(string req);
        #2;
        check(req, spsr_rdata, (kof(cur_sr[4:0]) == 0) ? 32'h0 : msp[kof(cur_sr[4:0])]);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [4:0] modes [8];
        modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                  5'b10111, 5'b11011, 5'b11111, 5'b00000};
        for (int i = 0; i < 400; i++) mdl[i] = '0;
        for (int i = 0; i < 6; i++) msp[i] = '0;
        cur_sr = 32'h0000_00D3;
        rst_n = 1'b0; wr_en = 0; sr_we = 0; spsr_we = 0; user_bank = 0;
        rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
        sr_wdata = 0; spsr_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #2;
        check("R1 status", sr_q, 32'h0000_00D3);
        check("R1 irq_mask", {31'd0, irq_mask}, 32'd1);
        check("R1 fiq_mask", {31'd0, fiq_mask}, 32'd1);
        check("R1 spsr", spsr_rdata, 32'h0);
        for (int r = 0; r < 16; r++) rd(r, 15 - r, "R1");

        // R2..R6: write every register and saved word in every mode
        for (int mi = 0; mi < 8; mi++) begin
            set_sr(32'h0000_00C0 | {27'd0, modes[mi]});
            for (int r = 0; r < 16; r++)
                wr(r, 32'hC000_003F | (mi << 16) | (r << 8));
            wr_spsr(32'h5000_0000 | mi);
        end
        for (int mi = 0; mi < 8; mi++) begin
            set_sr(32'h0000_00C0 | {27'd0, modes[mi]});
            for (int r = 0; r < 16; r++) rd(r, 15 - r, tag_of(r));
            chk_spsr("R5/R6 spsr");
        end

        // R7: status layout and mask outputs
        set_sr(32'hF900_0013);
        #2;
        check("R7 status", sr_q, 32'hF900_0013);
        check("R7 masks off", {30'd0, irq_mask, fiq_mask}, 32'd0);
        set_sr(32'h0000_0093);
        #2;
        check("R7 irq only", {30'd0, irq_mask, fiq_mask}, 32'd2);
        set_sr(32'h0000_0053);
        #2;
        check("R7 fiq only", {30'd0, irq_mask, fiq_mask}, 32'd1);

        // R8: alignment of register 15 per state
        set_sr(32'h0000_00D3);
        wr(15, 32'h1234_5677);
        rd(15, 0, "R8 word");
        set_sr(32'h0000_00F3);
        wr(15, 32'h1234_5677);
        rd(15, 0, "R8 half");
        set_sr(32'h0100_00D3);
        wr(15, 32'h1234_5677);
        rd(15, 0, "R8 byte");

        // R9: same-cycle read returns the old value
        set_sr(32'h0000_00D3);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hDEAD_0003;
        rd_a_idx = 4'd3; rd_b_idx = 4'd3;
        #2;
        check("R9 old a", rd_a_data, mdl[3]);
        check("R9 old b", rd_b_data, mdl[3]);
        @(negedge clk);
        wr_en = 1'b0;
        mdl[3] = 32'hDEAD_0003;
        #2;
        check("R9 new a", rd_a_data, 32'hDEAD_0003);

        // R10: forced user copies from interrupt and FIQ modes
        set_sr(32'h0000_00D2);
        user_bank = 1'b1;
        wr(13, 32'hABCD_0013);
        wr(14, 32'hABCD_0014);
        rd(13, 14, "R10 forced");
        rd(8, 12, "R10 forced hi");
        rd(0, 15, "R10 low");
        chk_spsr("R10 spsr");
        user_bank = 1'b0;
        rd(13, 14, "R10 private");
        set_sr(32'h0000_00D1);
        user_bank = 1'b1;
        rd(8, 13, "R10 fiq forced");
        user_bank = 1'b0;
        rd(8, 13, "R10 fiq private");
        set_sr(32'h0000_00D0);
        rd(13, 14, "R10 user view");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule